// File: doc/BRIEF.md
# Preamble-Trained Energy Threshold Slicer

This block turns a stream of integrated pulse energies, one small unsigned value per bit period, into hard data decisions without a fixed decision level. Each frame opens with a training section of two equal runs. The first run carries only zero bits, and the block averages their energy into a noise estimate. The second run alternates ones and zeros, and the block adds up its energy. Because an even-length alternating run holds equal numbers of ones and zeros, the mean energy per symbol over that run falls between the two bit levels. That mean becomes the slicing threshold for the data bits that follow.

An external phase sequencer drives three enables, one each for noise bits, training bits and data bits, and a frame-start pulse. A four-state machine sets which enable the block accepts. The states are IDLE, NOISE, PREAMBLE and SLICE. Reset enters IDLE, and IDLE leaves only on a frame start. A frame start moves every state to NOISE and clears all accumulated results. NOISE moves to PREAMBLE on the last accepted noise bit. PREAMBLE moves to SLICE on the last accepted training bit. SLICE holds until the next frame start. The training length is a power-of-two parameter, so the threshold and the noise average are right shifts and need no divider. The default length is 8.

Top module: `energy_slicer`

## Requirements
- R1: After reset, `noise_avg`, `pre_total`, `threshold`, `dec_bit` and `dec_valid` are all 0, and the phase enables have no effect until `frame_start` is pulsed.
- R2: A cycle with `frame_start` high clears `noise_avg`, `pre_total`, `threshold` and `dec_valid` on the next edge and starts the noise phase.
- R3: In the noise phase, `noise_avg` reads 0 until the TRAIN_LEN-th accepted `noise_en` sample. From that edge on it holds floor(sum of those samples / TRAIN_LEN).
- R4: The preamble phase begins on the edge of the last noise sample. `pre_total` and `threshold` read 0 until the TRAIN_LEN-th accepted `pre_en` sample. From that edge on, `pre_total` holds the exact sum of those samples and `threshold` holds floor(`pre_total` / TRAIN_LEN).
- R5: Cycles with the current phase's enable low add nothing, so training samples may be spread out with gaps.
- R6: An enable that does not belong to the current phase is ignored. This covers `pre_en` or `data_en` during noise, `data_en` during preamble, and `noise_en` or `pre_en` after training.
- R7: In the slice phase, a cycle with `data_en` high sets `dec_valid` to 1 on the next edge, with `dec_bit` = 1 when `energy` > `threshold` and 0 otherwise. After a cycle with `data_en` low, `dec_valid` is 0 and `dec_bit` keeps its last value.
- R8: An energy exactly equal to the threshold decides 0.
- R9: `frame_start` takes priority over any enable in the same cycle. That cycle's sample is not accumulated, and a frame start during training restarts training from empty sums.
- R10: With every training bit at full scale (15), `pre_total` = 120 with no overflow, `threshold` = 15, and a full-scale data energy decides 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | input | 1 | Pulse that clears results and opens the noise phase |
| noise_en | input | 1 | Current energy belongs to a noise (zero) bit |
| pre_en | input | 1 | Current energy belongs to an alternating training bit |
| data_en | input | 1 | Current energy belongs to a data bit to be decided |
| energy | input | EW (4) | Integrated energy of the current bit period |
| noise_avg | output | EW (4) | Mean noise-bit energy, 0 until noise phase complete |
| pre_total | output | EW+log2(TRAIN_LEN) (7) | Sum of training-bit energies, 0 until complete |
| threshold | output | EW (4) | Learned decision level, 0 until training complete |
| dec_bit | output | 1 | Hard decision of the last data bit |
| dec_valid | output | 1 | `dec_bit` was updated on the last edge |

## Verification
The training runs use mixed energies with a known sum. Some are interleaved with idle gaps and with foreign enables carrying full-scale energy, so any leaked sample would shift the averages. A noise sum that is not a multiple of eight separates truncation from rounding. The data patterns sit just above, exactly at and below the learned threshold, and at both ends of the range, which separates a strict compare from a non-strict one. A frame start that coincides with a noise sample, and one issued in the middle of the preamble, show whether restarts discard partial sums and that colliding sample.

// File: rtl/slicer_pkg.sv
package slicer_pkg;
    typedef enum logic [1:0] {
        PH_IDLE     = 2'd0,
        PH_NOISE    = 2'd1,
        PH_PREAMBLE = 2'd2,
        PH_SLICE    = 2'd3
    } phase_t;
endpackage

// File: rtl/slicer_phase_fsm.sv
module slicer_phase_fsm
    import slicer_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   frame_start,
    input  logic   noise_en,
    input  logic   pre_en,
    input  logic   data_en,
    input  logic   noise_last,
    input  logic   pre_last,
    output phase_t phase,
    output logic   noise_take,
    output logic   pre_take,
    output logic   data_take
);
    phase_t phase_nx;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) phase <= PH_IDLE;
        else        phase <= phase_nx;
    end

    // transitions; a frame start overrides everything
    always_comb begin
        phase_nx = phase;
        if (frame_start) begin
            phase_nx = PH_NOISE;
        end else begin
            unique case (phase)
                PH_IDLE:     phase_nx = PH_IDLE;
                PH_NOISE:    if (noise_last) phase_nx = PH_PREAMBLE;
                PH_PREAMBLE: if (pre_last)   phase_nx = PH_SLICE;
                PH_SLICE:    phase_nx = PH_SLICE;
            endcase
        end
    end

    // outputs: only the enable of the current phase is accepted
    always_comb begin
        noise_take = 1'b0;
        pre_take   = 1'b0;
        data_take  = 1'b0;
        unique case (phase)
            PH_IDLE:     ;
            PH_NOISE:    noise_take = noise_en && !frame_start;
            PH_PREAMBLE: pre_take   = pre_en   && !frame_start;
            PH_SLICE:    data_take  = data_en  && !frame_start;
        endcase
    end
endmodule

// File: rtl/energy_accum.sv
module energy_accum #(
    parameter int EW        = 4,
    parameter int TRAIN_LEN = 8,
    parameter bit MEAN      = 1'b0,
    parameter int OUT_W     = EW
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             take,
    input  logic [EW-1:0]    energy,
    output logic             last,
    output logic [OUT_W-1:0] result
);
    localparam int LOG2  = $clog2(TRAIN_LEN);
    localparam int SUM_W = EW + LOG2;
    localparam int CNT_W = $clog2(TRAIN_LEN + 1);

    logic [SUM_W-1:0] sum;
    logic [CNT_W-1:0] cnt;
    logic             done;

    assign last = take && !done && (cnt == CNT_W'(TRAIN_LEN - 1));

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            sum  <= '0;
            cnt  <= '0;
            done <= 1'b0;
        end else if (take && !done) begin
            sum <= sum + SUM_W'(energy);
            cnt <= cnt + 1'b1;
            if (last) done <= 1'b1;
        end
    end

    generate
        if (MEAN) begin : g_mean
            assign result = done ? sum[SUM_W-1:LOG2] : '0;
        end else begin : g_total
            assign result = done ? sum : '0;
        end
    endgenerate
endmodule

// File: rtl/bit_decider.sv
module bit_decider #(
    parameter int EW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          take,
    input  logic [EW-1:0] energy,
    input  logic [EW-1:0] threshold,
    output logic          dec_bit,
    output logic          dec_valid
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dec_bit   <= 1'b0;
            dec_valid <= 1'b0;
        end else if (clr) begin
            dec_valid <= 1'b0;
        end else begin
            dec_valid <= take;
            if (take) dec_bit <= (energy > threshold);
        end
    end
endmodule

// File: rtl/energy_slicer.sv
module energy_slicer
    import slicer_pkg::*;
#(
    parameter int EW        = 4,
    parameter int TRAIN_LEN = 8
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              frame_start,
    input  logic                              noise_en,
    input  logic                              pre_en,
    input  logic                              data_en,
    input  logic [EW-1:0]                     energy,
    output logic [EW-1:0]                     noise_avg,
    output logic [EW+$clog2(TRAIN_LEN)-1:0]   pre_total,
    output logic [EW-1:0]                     threshold,
    output logic                              dec_bit,
    output logic                              dec_valid
);
    localparam int LOG2  = $clog2(TRAIN_LEN);
    localparam int SUM_W = EW + LOG2;

    phase_t phase;
    logic   noise_take, pre_take, data_take;
    logic   noise_last, pre_last;

    slicer_phase_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_start(frame_start),
        .noise_en   (noise_en),
        .pre_en     (pre_en),
        .data_en    (data_en),
        .noise_last (noise_last),
        .pre_last   (pre_last),
        .phase      (phase),
        .noise_take (noise_take),
        .pre_take   (pre_take),
        .data_take  (data_take)
    );

    energy_accum #(.EW(EW), .TRAIN_LEN(TRAIN_LEN), .MEAN(1'b1), .OUT_W(EW)) u_noise (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (frame_start),
        .take  (noise_take),
        .energy(energy),
        .last  (noise_last),
        .result(noise_avg)
    );

    energy_accum #(.EW(EW), .TRAIN_LEN(TRAIN_LEN), .MEAN(1'b0), .OUT_W(SUM_W)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (frame_start),
        .take  (pre_take),
        .energy(energy),
        .last  (pre_last),
        .result(pre_total)
    );

    // mean per symbol over the even alternating run: a right shift
    assign threshold = pre_total[SUM_W-1:LOG2];

    bit_decider #(.EW(EW)) u_dec (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (frame_start),
        .take     (data_take),
        .energy   (energy),
        .threshold(threshold),
        .dec_bit  (dec_bit),
        .dec_valid(dec_valid)
    );
endmodule

// File: rtl/slicer_checker.sv
module slicer_checker
    import slicer_pkg::*;
#(
    parameter int EW    = 4,
    parameter int SUM_W = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             frame_start,
    input logic             data_en,
    input logic [EW-1:0]    energy,
    input phase_t           phase,
    input logic [EW-1:0]    noise_avg,
    input logic [SUM_W-1:0] pre_total,
    input logic [EW-1:0]    threshold,
    input logic             dec_bit,
    input logic             dec_valid
);
    a_r2_clear: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> (noise_avg == '0 && pre_total == '0 && threshold == '0 && !dec_valid));

    a_r4_zero_in_noise: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_NOISE) |-> (pre_total == '0 && threshold == '0));

    a_r6_no_early_decision: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != PH_SLICE) |=> !dec_valid);

    a_r7_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_SLICE && data_en && !frame_start) |=> dec_valid);

    a_r7_decision: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_SLICE && data_en && !frame_start) |=> (dec_bit == ($past(energy) > $past(threshold))));

    a_r4_thr_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_SLICE && !frame_start) |=> ($stable(threshold) && $stable(noise_avg)));
endmodule

bind energy_slicer slicer_checker #(.EW(EW), .SUM_W(SUM_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_start(frame_start),
    .data_en    (data_en),
    .energy     (energy),
    .phase      (phase),
    .noise_avg  (noise_avg),
    .pre_total  (pre_total),
    .threshold  (threshold),
    .dec_bit    (dec_bit),
    .dec_valid  (dec_valid)
);

// File: tb/energy_slicer_test.sv
module energy_slicer_test;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frame_start = 1'b0;
    logic       noise_en = 1'b0;
    logic       pre_en = 1'b0;
    logic       data_en = 1'b0;
    logic [3:0] energy = '0;
    logic [3:0] noise_avg;
    logic [6:0] pre_total;
    logic [3:0] threshold;
    logic       dec_bit;
    logic       dec_valid;

    int total = 0;
    int bad = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    energy_slicer uut (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
        .noise_en(noise_en), .pre_en(pre_en), .data_en(data_en),
        .energy(energy), .noise_avg(noise_avg), .pre_total(pre_total),
        .threshold(threshold), .dec_bit(dec_bit), .dec_valid(dec_valid)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // called at a falling edge: drive inputs, let one rising edge pass
    task automatic cyc(input logic fs, input logic ne, input logic pe,
                       input logic de, input int e);
        frame_start = fs; noise_en = ne; pre_en = pe; data_en = de;
        energy = 4'(e);
        @(negedge clk);
        frame_start = 0; noise_en = 0; pre_en = 0; data_en = 0;
    endtask

    task automatic t_reset;
        rst_n = 0;
        repeat (3) cyc(0, 0, 0, 0, 0);
        chk("R1 noise_avg", noise_avg, 0);
        chk("R1 pre_total", pre_total, 0);
        chk("R1 threshold", threshold, 0);
        chk("R1 dec_valid", dec_valid, 0);
        chk("R1 dec_bit", dec_bit, 0);
        rst_n = 1;
        for (int i = 0; i < 10; i++) cyc(0, 1, 1, 1, 9);
        chk("R1 noise_avg before frame", noise_avg, 0);
        chk("R1 pre_total before frame", pre_total, 0);
        chk("R1 dec_valid before frame", dec_valid, 0);
    endtask

    task automatic t_train_basic;
        int nv[8] = '{3, 5, 2, 4, 6, 1, 7, 0};   // sum 28, mean 3
        int pv[8] = '{12, 1, 14, 2, 13, 0, 11, 3}; // sum 56, threshold 7
        cyc(1, 0, 0, 0, 0);
        chk("R2 noise_avg after start", noise_avg, 0);
        for (int i = 0; i < 8; i++) begin
            if (i == 3) begin
                cyc(0, 0, 1, 1, 15); // R6 foreign enables in noise
                cyc(0, 0, 0, 0, 15); // R5 gap
            end
            cyc(0, 1, 0, 0, nv[i]);
            if (i == 6) chk("R3 noise_avg before last", noise_avg, 0);
        end
        chk("R3 noise_avg", noise_avg, 3);
        chk("R6 dec_valid in noise", dec_valid, 0);
        cyc(0, 0, 0, 1, 15);
        chk("R6 data_en in preamble", dec_valid, 0);
        cyc(0, 1, 0, 0, 15);
        chk("R6 noise_en in preamble", noise_avg, 3);
        for (int i = 0; i < 8; i++) begin
            if (i == 5) cyc(0, 0, 0, 0, 15); // R5 gap
            cyc(0, 0, 1, 0, pv[i]);
            if (i == 6) begin
                chk("R4 pre_total before last", pre_total, 0);
                chk("R4 threshold before last", threshold, 0);
            end
        end
        chk("R4 pre_total", pre_total, 56);
        chk("R4 threshold", threshold, 7);
        chk("R4 noise_avg kept", noise_avg, 3);
    endtask

    task automatic t_slice;
        int ev[5] = '{8, 7, 0, 15, 6};
        for (int i = 0; i < 5; i++) begin
            cyc(0, 0, 0, 1, ev[i]);
            chk("R7 dec_valid", dec_valid, 1);
            if (ev[i] == 7) chk("R8 equal decides 0", dec_bit, 0);
            else chk("R7 dec_bit", dec_bit, (ev[i] > 7) ? 1 : 0);
        end
        cyc(0, 0, 0, 1, 12);
        cyc(0, 0, 0, 0, 0);
        chk("R7 dec_valid drops", dec_valid, 0);
        chk("R7 dec_bit holds", dec_bit, 1);
        cyc(0, 1, 1, 0, 15);
        chk("R6 pre_total after training", pre_total, 56);
        chk("R6 threshold after training", threshold, 7);
        chk("R6 noise_avg after training", noise_avg, 3);
    endtask

    task automatic t_restart;
        cyc(1, 0, 0, 0, 0);
        for (int i = 0; i < 8; i++) cyc(0, 1, 0, 0, 2);
        chk("R3 noise_avg flat", noise_avg, 2);
        for (int i = 0; i < 3; i++) cyc(0, 0, 1, 0, 15);
        cyc(1, 1, 0, 0, 15); // restart mid-preamble, colliding noise sample
        chk("R9 noise_avg cleared", noise_avg, 0);
        chk("R2 pre_total cleared", pre_total, 0);
        chk("R2 dec_valid cleared", dec_valid, 0);
        for (int i = 0; i < 7; i++) cyc(0, 1, 0, 0, 1);
        chk("R9 colliding sample not taken", noise_avg, 0);
        cyc(0, 1, 0, 0, 2);
        chk("R3 noise_avg floor", noise_avg, 1);
        for (int i = 0; i < 8; i++) cyc(0, 0, 1, 0, 15);
        chk("R10 pre_total full scale", pre_total, 120);
        chk("R10 threshold full scale", threshold, 15);
        cyc(0, 0, 0, 1, 15);
        chk("R10 dec_valid", dec_valid, 1);
        chk("R10 full-scale decides 0", dec_bit, 0);
        cyc(0, 0, 0, 1, 14);
        chk("R10 below decides 0", dec_bit, 0);
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_train_basic();
        t_slice();
        t_restart();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule